// File: doc/BRIEF.md
# Ping-Pong Peripheral DMA Channel

This block is a single channel of a DMA engine that moves 32-bit words between a memory-side port and a peripheral-side port. Software programs it through six 32-bit registers: a control word, a status word, and a start pointer and sequence word for each side. Once enabled, the channel copies one word per move. In each move it reads the source port and writes the destination port in the same cycle. A move can be paced by one selected peripheral request line.

There are two modes. In one-shot mode the channel moves a single block of count+1 words and then stops. In continuous mode it reloads the count at every block end and keeps running. With double buffering selected, each block is one half of a buffer. The two halves alternate, and a status flag toggles at every half so software can tell which half has just filled. Pointers written while the channel runs are picked up at the next pointer reload, so the next buffer can be queued ahead of time. Selecting request line 31 freezes the transfer without losing its position, and software can then read the remaining word count.

Top module: `pp_dma_chan`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and neither port is enabled.
- R2: The registers are selected by `reg_addr[4:2]`: 0 control, 1 status, 4 memory pointer, 5 memory sequence, 6 peripheral pointer, 7 peripheral sequence. The pointers read back as written. The memory sequence implements bit 19 (double buffer) and bits 18:16 (wrap code). The peripheral sequence implements bits 18:16 only. All other sequence bits read 0.
- R3: The control word has these fields: enable bit 31, interrupt enable bit 30, hold bit 29, direction bit 28, once bit 27, flow bit 21, request select bits 20:16 and count bits 15:2. Writing enable=1 while enable is 0 starts a job from the programmed pointers. In each move, `mem_en` and `per_en` are both high and exactly one side writes. With direction 0 the channel writes memory with the peripheral data; with direction 1 it writes the peripheral with the memory data.
- R4: With once set, the channel moves count+1 words and then clears busy and the enable bit.
- R5: With flow set, a word moves only in a cycle where the selected request input is high. With flow clear, a word moves every cycle.
- R6: Request select 31 stops all moves. Busy stays 1 and the remaining count is kept and stays readable. Selecting a valid line again resumes from where the job stopped.
- R7: The status word has busy at bit 31, end-of-count at bit 30, the half flag at bit 28 and the remaining words minus one at bits 15:2. The count drops by one per move. Writing 1 to status bit 30 clears end-of-count.
- R8: `irq` is high exactly when interrupt enable and end-of-count are both set.
- R9: Each pointer advances 4 bytes per word. Wrap code 0 gives linear addresses. Memory-side codes 1..7 wrap after 32, 64, 128, 256, 512, 1024 or 2048 words. Peripheral-side codes 1..7 wrap after 1, 2, 4, 8, 16, 32 or 64 words. A wrapping pointer returns to its start pointer.
- R10: In continuous mode without double buffer, every block end sets end-of-count, reloads the count, and reloads both pointers from the pointer registers.
- R11: With double buffer set, the half flag starts at 0 and toggles at every block end. The end of the first half continues the addresses. The end of the second half reloads the pointers.
- R12: Clearing enable stops the channel and clears busy. Hold (bit 29) pauses moves while it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | End-of-count interrupt |
| mem_en | output | 1 | Memory port access this cycle |
| mem_we | output | 1 | Memory port write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid in the same cycle |
| per_en | output | 1 | Peripheral port access this cycle |
| per_we | output | 1 | Peripheral port write |
| per_addr | output | AW | Peripheral byte address |
| per_wdata | output | 32 | Peripheral write data |
| per_rdata | input | 32 | Peripheral read data, valid in the same cycle |
| per_dreq | input | NREQ | Peripheral request lines |

## Verification
The assertions assume the following about the inputs:
- Both ports return read data in the same cycle and accept writes without stalling.
- Control is never written with enable set in the same cycle that a one-shot job reaches its last word.

The stimulus keeps within these limits. The bench models both ports as zero-wait arrays. It drives request pulses one cycle wide, between clock edges. It makes control writes only while the channel is idle, frozen, held, or waiting on a request line that is low.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
    localparam int CNT_W  = 14;
    localparam int SEL_W  = 5;
    localparam int WRAP_W = 12;
    localparam logic [SEL_W-1:0] SEL_NONE = '1;

    typedef enum logic [2:0] {
        IDX_CTRL = 3'd0,
        IDX_STAT = 3'd1,
        IDX_MPTR = 3'd4,
        IDX_MSEQ = 3'd5,
        IDX_PPTR = 3'd6,
        IDX_PSEQ = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic             enable;
        logic             ie;
        logic             hold;
        logic             to_per;
        logic             once;
        logic             flow;
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(input logic [31:0] w);
        ctrl_t c;
        c.enable = w[31];
        c.ie     = w[30];
        c.hold   = w[29];
        c.to_per = w[28];
        c.once   = w[27];
        c.flow   = w[21];
        c.sel    = w[20:16];
        c.cnt    = w[15:2];
        return c;
    endfunction

    function automatic logic [31:0] pack_ctrl(input ctrl_t c);
        return {c.enable, c.ie, c.hold, c.to_per, c.once, 5'b0, c.flow,
                c.sel, c.cnt, 2'b00};
    endfunction

    // Word count after which a pointer returns to its start; 0 = linear.
    function automatic logic [WRAP_W-1:0] wrap_words(input logic mem_side,
                                                     input logic [2:0] code);
        if (code == 3'd0) return '0;
        if (mem_side) return WRAP_W'(16) << code;
        return WRAP_W'(1) << (code - 3'd1);
    endfunction
endpackage

// File: rtl/pp_dma_regs.sv
module pp_dma_regs
    import pp_dma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  reg_idx_e         idx,
    input  logic [31:0]      wdata,
    input  logic             blk_done,
    output ctrl_t            ctrl,
    output logic             start,
    output logic [CNT_W-1:0] start_cnt,
    output logic [AW-1:0]    mptr,
    output logic [AW-1:0]    pptr,
    output logic [2:0]       mwrap,
    output logic [2:0]       pwrap,
    output logic             dbl,
    output logic             stat_clr
);
    logic wr_ctrl;

    assign wr_ctrl   = wr && (idx == IDX_CTRL);
    assign start     = wr_ctrl && wdata[31] && !ctrl.enable;
    assign start_cnt = wdata[15:2];
    assign stat_clr  = wr && (idx == IDX_STAT) && wdata[30];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            mptr  <= '0;
            pptr  <= '0;
            mwrap <= '0;
            pwrap <= '0;
            dbl   <= 1'b0;
        end else begin
            if (wr_ctrl)       ctrl <= unpack_ctrl(wdata);
            else if (blk_done) ctrl.enable <= 1'b0;
            if (wr && idx == IDX_MPTR) mptr <= wdata[AW-1:0];
            if (wr && idx == IDX_PPTR) pptr <= wdata[AW-1:0];
            if (wr && idx == IDX_MSEQ) begin
                dbl   <= wdata[19];
                mwrap <= wdata[18:16];
            end
            if (wr && idx == IDX_PSEQ) pwrap <= wdata[18:16];
        end
    end
endmodule

// File: rtl/pp_dma_seq.sv
module pp_dma_seq
    import pp_dma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic             start,
    input  logic [CNT_W-1:0] start_cnt,
    input  logic             req_line,
    input  logic             dbl,
    input  logic             eoc_clr,
    output logic             move,
    output logic             load,
    output logic             blk_done,
    output logic             busy,
    output logic             eoc,
    output logic             ping,
    output logic [CNT_W-1:0] cnt
);
    logic last, blk_end;

    assign last     = (cnt == '0);
    assign move     = busy && ctrl.enable && !ctrl.hold && (ctrl.sel != SEL_NONE)
                      && (!ctrl.flow || req_line);
    assign blk_end  = move && last;
    assign blk_done = blk_end && ctrl.once;
    // Pointers reload on start and at block ends, except after the first half.
    assign load     = start || (blk_end && !ctrl.once && !(dbl && !ping));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            ping <= 1'b0;
            eoc  <= 1'b0;
        end else begin
            if (start) begin
                busy <= 1'b1;
                cnt  <= start_cnt;
                ping <= 1'b0;
            end else begin
                if (!ctrl.enable || blk_done) busy <= 1'b0;
                if (move) begin
                    if (last) begin
                        if (!ctrl.once) cnt <= ctrl.cnt;
                        if (dbl) ping <= !ping;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            end
            if (blk_end)      eoc <= 1'b1;
            else if (eoc_clr) eoc <= 1'b0;
        end
    end
endmodule

// File: rtl/pp_dma_addr.sv
module pp_dma_addr
    import pp_dma_pkg::*;
#(
    parameter bit MEM_SIDE = 1'b1,
    parameter int AW       = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] base_in,
    input  logic [2:0]    wrap_code,
    output logic [AW-1:0] addr
);
    localparam int OFF_W = CNT_W + 2;

    logic [AW-1:0]     base;
    logic [OFF_W-1:0]  off;
    logic [WRAP_W-1:0] lim;

    assign lim  = wrap_words(MEM_SIDE, wrap_code);
    assign addr = base + AW'({off, 2'b00});

    always_ff @(posedge clk) begin
        if (rst) begin
            base <= '0;
            off  <= '0;
        end else if (load) begin
            base <= base_in;
            off  <= '0;
        end else if (step) begin
            if (lim != '0 && off == OFF_W'(lim) - OFF_W'(1)) off <= '0;
            else                                            off <= off + 1'b1;
        end
    end
endmodule

// File: rtl/pp_dma_chan.sv
module pp_dma_chan
    import pp_dma_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NREQ = 31
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_wr,
    input  logic [7:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            irq,
    output logic            mem_en,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [31:0]     mem_wdata,
    input  logic [31:0]     mem_rdata,
    output logic            per_en,
    output logic            per_we,
    output logic [AW-1:0]   per_addr,
    output logic [31:0]     per_wdata,
    input  logic [31:0]     per_rdata,
    input  logic [NREQ-1:0] per_dreq
);
    localparam int NLINE = 2 ** SEL_W;

    reg_idx_e         idx;
    ctrl_t            ctrl;
    logic             start, blk_done, stat_clr, dbl;
    logic [CNT_W-1:0] start_cnt, cnt;
    logic [AW-1:0]    mptr, pptr;
    logic [2:0]       mwrap, pwrap;
    logic             move, load, busy, eoc, ping, req_line;
    logic [NLINE-1:0] dreq_pad;
    logic [AW-1:0]    base_in   [2];
    logic [2:0]       wcode     [2];
    logic [AW-1:0]    side_addr [2];

    assign idx      = reg_idx_e'(reg_addr[4:2]);
    assign dreq_pad = {{(NLINE - NREQ){1'b0}}, per_dreq};
    assign req_line = dreq_pad[ctrl.sel];

    pp_dma_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .idx(idx), .wdata(reg_wdata),
        .blk_done(blk_done), .ctrl(ctrl), .start(start), .start_cnt(start_cnt),
        .mptr(mptr), .pptr(pptr), .mwrap(mwrap), .pwrap(pwrap), .dbl(dbl),
        .stat_clr(stat_clr)
    );

    pp_dma_seq u_seq (
        .clk(clk), .rst(rst), .ctrl(ctrl), .start(start), .start_cnt(start_cnt),
        .req_line(req_line), .dbl(dbl), .eoc_clr(stat_clr), .move(move),
        .load(load), .blk_done(blk_done), .busy(busy), .eoc(eoc), .ping(ping),
        .cnt(cnt)
    );

    assign base_in[0] = mptr;
    assign base_in[1] = pptr;
    assign wcode[0]   = mwrap;
    assign wcode[1]   = pwrap;

    for (genvar g = 0; g < 2; g++) begin : g_side
        pp_dma_addr #(.MEM_SIDE(g == 0), .AW(AW)) u_addr (
            .clk(clk), .rst(rst), .load(load), .step(move),
            .base_in(base_in[g]), .wrap_code(wcode[g]), .addr(side_addr[g])
        );
    end

    assign mem_addr  = side_addr[0];
    assign per_addr  = side_addr[1];
    assign mem_en    = move;
    assign per_en    = move;
    assign mem_we    = move && !ctrl.to_per;
    assign per_we    = move && ctrl.to_per;
    assign mem_wdata = per_rdata;
    assign per_wdata = mem_rdata;
    assign irq       = ctrl.ie && eoc;

    always_comb begin
        reg_rdata = '0;
        case (idx)
            IDX_CTRL: reg_rdata = pack_ctrl(ctrl);
            IDX_STAT: reg_rdata = {busy, eoc, 1'b0, ping, 12'b0, cnt, 2'b00};
            IDX_MPTR: reg_rdata = 32'(mptr);
            IDX_MSEQ: reg_rdata = {12'b0, dbl, mwrap, 16'b0};
            IDX_PPTR: reg_rdata = 32'(pptr);
            IDX_PSEQ: reg_rdata = {13'b0, pwrap, 16'b0};
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pp_dma_chan_chk.sv
module pp_dma_chan_chk
    import pp_dma_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input ctrl_t            ctrl,
    input logic             busy,
    input logic             req_line,
    input logic [CNT_W-1:0] cnt,
    input logic             mem_en,
    input logic             per_en,
    input logic             mem_we,
    input logic             per_we
);
    assert_move_busy_R3: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> busy && per_en && (mem_we != per_we));

    assert_flow_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl.flow && !req_line) |-> !mem_en);

    assert_freeze_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl.sel == SEL_NONE) |-> (!mem_en && !per_en));

    assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_en && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    assert_once_stop_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_en && cnt == '0 && ctrl.once) |=> !busy);

    assert_hold_pause_R12: assert property (@(posedge clk) disable iff (rst)
        ctrl.hold |-> !mem_en);
endmodule

bind pp_dma_chan pp_dma_chan_chk u_chk (
    .clk(clk), .rst(rst), .ctrl(ctrl), .busy(busy), .req_line(req_line),
    .cnt(cnt), .mem_en(mem_en), .per_en(per_en), .mem_we(mem_we), .per_we(per_we)
);

// File: tb/sim_pp_dma_chan.sv
`timescale 1ns/1ps
module sim_pp_dma_chan;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, mem_en, mem_we, per_en, per_we;
    logic [31:0] mem_addr, per_addr, mem_wdata, per_wdata, mem_rdata, per_rdata;
    logic [30:0] per_dreq = '0;

    logic [31:0] marr [256];
    logic [31:0] parr [64];
    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #2.5 clk = ~clk;

    pp_dma_chan u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .per_en(per_en),
        .per_we(per_we), .per_addr(per_addr), .per_wdata(per_wdata),
        .per_rdata(per_rdata), .per_dreq(per_dreq)
    );

    assign mem_rdata = marr[mem_addr[9:2]];
    assign per_rdata = parr[per_addr[7:2]];

    always @(posedge clk) begin
        if (mem_en && mem_we) marr[mem_addr[9:2]] <= mem_wdata;
        if (per_en && per_we) parr[per_addr[7:2]] <= per_wdata;
    end

    localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h04, A_MPTR = 8'h10,
                           A_MSEQ = 8'h14, A_PPTR = 8'h18, A_PSEQ = 8'h1C;

    function automatic logic [31:0] mk(input bit en, input bit ie, input bit hold,
                                       input bit to_per, input bit once,
                                       input bit flow, input int sel, input int cnt);
        return {en, ie, hold, to_per, once, 5'b0, flow, 5'(sel), 14'(cnt), 2'b00};
    endfunction

    function automatic logic [31:0] st(input bit busy, input bit eoc, input bit half,
                                       input int cnt);
        return {busy, eoc, 1'b0, half, 12'b0, 14'(cnt), 2'b00};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int line, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); per_dreq[line] = 1'b1;
            @(negedge clk); per_dreq[line] = 1'b0;
        end
    endtask

    task automatic fill();
        for (int i = 0; i < 256; i++) marr[i] = 32'hDEAD0000 + i;
        for (int i = 0; i < 64; i++)  parr[i] = 32'hA0000000 + i;
    endtask

    task automatic setup(input logic [31:0] mp, input logic [31:0] ms,
                         input logic [31:0] pp, input logic [31:0] ps);
        wr(A_MPTR, mp); wr(A_MSEQ, ms); wr(A_PPTR, pp); wr(A_PSEQ, ps);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CTRL, v); chk("R1 ctrl after reset", v, 0);
        rd(A_STAT, v); chk("R1 status after reset", v, 0);
        rd(A_MSEQ, v); chk("R1 mseq after reset", v, 0);
        chk("R1 irq/ports after reset", {29'b0, irq, mem_en, per_en}, 0);
        wr(A_MPTR, 32'h1234_5678); rd(A_MPTR, v); chk("R2 mptr readback", v, 32'h1234_5678);
        wr(A_MSEQ, 32'hFFFF_FFFF); rd(A_MSEQ, v); chk("R2 mseq bits", v, 32'h000F_0000);
        wr(A_PSEQ, 32'hFFFF_FFFF); rd(A_PSEQ, v); chk("R2 pseq bits", v, 32'h0007_0000);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        fill(); setup(32'h40, 0, 0, 0);
        wr(A_CTRL, mk(1, 1, 0, 0, 1, 0, 0, 3));
        idle(10);
        for (int i = 0; i < 4; i++) chk("R3 per->mem word", marr[16+i], parr[i]);
        chk("R4 word past block untouched", marr[20], 32'hDEAD0000 + 20);
        rd(A_STAT, v); chk("R4 R7 status after one-shot", v, st(0, 1, 0, 0));
        rd(A_CTRL, v); chk("R4 enable self-cleared", v, mk(0, 1, 0, 0, 1, 0, 0, 3));
        chk("R8 irq with ie and eoc", {31'b0, irq}, 1);
        wr(A_STAT, 32'h4000_0000);
        rd(A_STAT, v); chk("R7 eoc write-1 clear", v, 0);
        chk("R8 irq after clear", {31'b0, irq}, 0);
    endtask

    task automatic t_per_wrap();
        logic [31:0] v;
        fill(); setup(32'h80, 0, 0, 32'h0002_0000);
        wr(A_CTRL, mk(1, 0, 0, 1, 1, 0, 0, 3));
        idle(10);
        chk("R9 R3 per wrap 2 word0", parr[0], 32'hDEAD0000 + 34);
        chk("R9 R3 per wrap 2 word1", parr[1], 32'hDEAD0000 + 35);
        chk("R9 per word2 untouched", parr[2], 32'hA0000002);
        rd(A_STAT, v); chk("R8 no irq without ie", {31'b0, irq}, 0);
        wr(A_STAT, 32'h4000_0000);
    endtask

    task automatic t_mem_wrap();
        fill(); setup(32'h0, 32'h0001_0000, 0, 0);
        wr(A_CTRL, mk(1, 0, 0, 0, 1, 0, 0, 39));
        idle(60);
        chk("R9 mem wrap32 word0", marr[0], parr[32]);
        chk("R9 mem wrap32 word7", marr[7], parr[39]);
        chk("R9 mem wrap32 word8", marr[8], parr[8]);
        chk("R9 mem wrap32 word31", marr[31], parr[31]);
        chk("R9 mem word32 untouched", marr[32], 32'hDEAD0000 + 32);
        wr(A_STAT, 32'h4000_0000);
    endtask

    task automatic t_flow_freeze();
        logic [31:0] v;
        fill(); setup(32'h40, 0, 0, 0);
        wr(A_CTRL, mk(1, 0, 0, 0, 1, 1, 5, 7));
        idle(5);
        rd(A_STAT, v); chk("R5 no move without request", v, st(1, 0, 0, 7));
        pulse(5, 3);
        rd(A_STAT, v); chk("R5 three requests three words", v, st(1, 0, 0, 4));
        per_dreq[4] = 1'b1; idle(5); per_dreq[4] = 1'b0;
        rd(A_STAT, v); chk("R5 other line ignored", v, st(1, 0, 0, 4));
        wr(A_CTRL, mk(1, 0, 0, 0, 1, 1, 31, 7));
        per_dreq = '1; idle(10);
        rd(A_STAT, v); chk("R6 frozen with requests", v, st(1, 0, 0, 4));
        wr(A_CTRL, mk(1, 0, 0, 0, 1, 0, 31, 7));
        idle(10); per_dreq = '0;
        rd(A_STAT, v); chk("R6 frozen with flow off", v, st(1, 0, 0, 4));
        chk("R6 word3 not written", marr[19], 32'hDEAD0000 + 19);
        chk("R5 word2 written", marr[18], parr[2]);
        wr(A_CTRL, mk(1, 0, 0, 0, 1, 0, 5, 7));
        idle(10);
        chk("R6 resume completes", marr[23], parr[7]);
        chk("R6 resume continues", marr[19], parr[3]);
        wr(A_STAT, 32'h4000_0000);
    endtask

    task automatic t_hold_disable();
        logic [31:0] v;
        fill(); setup(32'h40, 0, 0, 0);
        wr(A_CTRL, mk(1, 0, 1, 0, 1, 0, 0, 7));
        idle(5);
        rd(A_STAT, v); chk("R12 hold pauses", v, st(1, 0, 0, 7));
        wr(A_CTRL, mk(0, 0, 1, 0, 1, 0, 0, 7));
        rd(A_STAT, v); chk("R12 disable clears busy", v, st(0, 0, 0, 7));
        wr(A_CTRL, mk(0, 0, 0, 0, 1, 0, 0, 7));
        idle(5);
        chk("R12 no move when disabled", marr[16], 32'hDEAD0000 + 16);
    endtask

    task automatic t_cont_single();
        logic [31:0] v;
        fill(); setup(32'h40, 0, 0, 0);
        wr(A_CTRL, mk(1, 0, 0, 0, 0, 1, 2, 1));
        pulse(2, 1);
        wr(A_MPTR, 32'h100);
        pulse(2, 1);
        rd(A_STAT, v); chk("R10 block end reloads count", v, st(1, 1, 0, 1));
        chk("R10 first block word1", marr[17], parr[1]);
        wr(A_STAT, 32'h4000_0000);
        pulse(2, 2);
        chk("R10 reload to new mem pointer", marr[64], parr[0]);
        chk("R10 reload per pointer", marr[65], parr[1]);
        chk("R10 old area not extended", marr[18], 32'hDEAD0000 + 18);
        wr(A_CTRL, 0); wr(A_STAT, 32'h4000_0000);
    endtask

    task automatic t_cont_dbl();
        logic [31:0] v;
        fill(); setup(32'h40, 32'h0008_0000, 0, 0);
        wr(A_CTRL, mk(1, 0, 0, 0, 0, 1, 2, 1));
        pulse(2, 2);
        rd(A_STAT, v); chk("R11 first half flag", v, st(1, 1, 1, 1));
        wr(A_STAT, 32'h4000_0000);
        wr(A_MPTR, 32'h100);
        pulse(2, 2);
        rd(A_STAT, v); chk("R11 second half flag", v, st(1, 1, 0, 1));
        chk("R11 second half continues mem", marr[18], parr[2]);
        chk("R11 second half continues mem+1", marr[19], parr[3]);
        chk("R11 no early reload", marr[64], 32'hDEAD0000 + 64);
        wr(A_STAT, 32'h4000_0000);
        pulse(2, 2);
        chk("R11 buffer end reloads mem", marr[64], parr[0]);
        chk("R11 buffer end reloads per", marr[65], parr[1]);
        wr(A_CTRL, 0); wr(A_STAT, 32'h4000_0000);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        fill();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        wr(A_MSEQ, 0); wr(A_PSEQ, 0);
        t_oneshot();
        t_per_wrap();
        t_mem_wrap();
        t_flow_freeze();
        t_hold_disable();
        t_cont_single();
        t_cont_dbl();
        finish_run();
    end
endmodule